// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block sits behind the synchronous pins of a pipelined burst static RAM. On every rising clock edge it samples three chip selects of mixed polarity, two burst-start strobes (one meant for a processor, one for a cache controller), an advance input and the write controls. From these it picks one cycle type: deselect, start a read burst, start a write burst, step the burst, or hold the burst. It then drives the array address, a write strobe for each byte lane, the output-register load and the output-drive enable for the shared data bus.

A two-bit burst counter generates addresses inside an aligned group of four words. The group order is either linear (the two low bits count up and wrap) or interleaved (the two low bits are XORed with the count), chosen by a static mode input. Write data is taken from the data input at the same edge that decodes the write. Read data passes through one output register, so it appears one clock after the edge that captured its address. A small behavioural array with two 8-bit lanes is included so the whole read and write path can be checked at the ports. The shared bus is split into an input, an output and a drive enable.

Top module: `bsram_cycle_ctl`

## Requirements
- R1: While reset is asserted and right after it is released, `dq_drive` is 0.
- R2: When a start strobe is honoured (`start_ctl_n` low, or `start_cpu_n` low with `cs0_n` low) and the chip is not selected (selected means `cs0_n`=0, `cs1`=1 and `cs2_n`=0 together), the cycle writes nothing and `dq_drive` is 0 after the following edge.
- R3: With the chip selected and `start_cpu_n` low, a read burst starts at `addr`; all write controls are ignored on that cycle and the array is left unchanged.
- R4: While `cs0_n` is high, `start_cpu_n` is ignored; the cycle is decided by `start_ctl_n` and `next_n` alone.
- R5: With the chip selected, `start_cpu_n` high and `start_ctl_n` low, a burst starts at `addr`; it is a write when the write controls request any lane, otherwise a read.
- R6: With both start strobes high and `next_n` low the burst steps; with `burst_ilv`=0 the two low address bits count up by one and wrap within the aligned group of four, the upper bits staying fixed.
- R7: With `burst_ilv`=1 the burst address in step k of the burst is the start address with its two low bits XORed with k (mod 4).
- R8: With both start strobes high and `next_n` high the burst holds its current address.
- R9: `wr_all_n` low writes both lanes, whatever `lane_wr_en_n` and `lane_sel_n` are.
- R10: With `wr_all_n` high and `lane_wr_en_n` low, lane i is written only when `lane_sel_n[i]` is low; lane 0 is `dq_in[7:0]`, lane 1 is `dq_in[15:8]`. With both `lane_sel_n` bits high, or with `lane_wr_en_n` high, the cycle is a read.
- R11: `out_en_n` gates the bus without a clock: when it is high `dq_drive` is 0 at once; when it is low and read data is held, `dq_drive` is 1.
- R12: Read data for an address captured at edge N appears on `dq_out` with `dq_drive` high after edge N+1, not after edge N; write data is taken from `dq_in` at the edge that decodes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs0_n | input | 1 | Chip select, active low; also gates `start_cpu_n` |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| start_cpu_n | input | 1 | Processor burst-start strobe, always a read |
| start_ctl_n | input | 1 | Controller burst-start strobe, read or write |
| next_n | input | 1 | Burst advance, active low |
| addr | input | AW (6) | External word address |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| wr_all_n | input | 1 | Write all lanes, active low |
| lane_wr_en_n | input | 1 | Enables per-lane writes, active low |
| lane_sel_n | input | 2 | Per-lane write select, active low |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| dq_in | input | 16 | Data bus input side |
| dq_out | output | 16 | Data bus output side |
| dq_drive | output | 1 | Data bus drive enable |

## Verification
A wrong burst count or base shows up as a wrong word on `dq_out` one edge after the bad address is used, so burst tests compare every beat of linear, interleaved and held bursts against a bench model of the group order. A wrong decode of the select, strobe or write terms shows up either as array contents that change when they must not, or as a bus that is driven when it must stay released; each such case is followed by a read-back of the touched word. The one-stage read pipeline is checked by sampling the bus both after the capture edge and after the next one.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  typedef enum logic [2:0] {
    OP_DESEL    = 3'd0,
    OP_START_RD = 3'd1,
    OP_START_WR = 3'd2,
    OP_STEP     = 3'd3,
    OP_HOLD     = 3'd4
  } cyc_op_e;

  // Low address bits of burst beat cnt starting from base.
  function automatic logic [1:0] beat_low(input logic [1:0] base,
                                          input logic [1:0] cnt,
                                          input logic       ilv);
    beat_low = ilv ? (base ^ cnt) : (base + cnt);
  endfunction

endpackage

// File: rtl/bsram_cmd_decode.sv
module bsram_cmd_decode
  import bsram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             cs0_n,
  input  logic             cs1,
  input  logic             cs2_n,
  input  logic             start_cpu_n,
  input  logic             start_ctl_n,
  input  logic             next_n,
  input  logic             wr_all_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  output cyc_op_e          op,
  output logic [LANES-1:0] we,
  output logic             rd_req
);

  logic [LANES-1:0] lane_req;
  logic             selected;
  logic             cpu_taken;
  logic             any_wr;
  logic             wr_allowed;

  // Per-lane request: global write overrides the lane enables.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_req[i] = !wr_all_n || (!lane_wr_en_n && !lane_sel_n[i]);
  end

  always_comb begin
    selected  = !cs0_n && cs1 && !cs2_n;
    cpu_taken = !start_cpu_n && !cs0_n;
    any_wr    = |lane_req;

    if (cpu_taken) begin
      op = selected ? OP_START_RD : OP_DESEL;
    end else if (!start_ctl_n) begin
      if (!selected)   op = OP_DESEL;
      else if (any_wr) op = OP_START_WR;
      else             op = OP_START_RD;
    end else if (!next_n) begin
      op = OP_STEP;
    end else begin
      op = OP_HOLD;
    end

    wr_allowed = (op == OP_START_WR) || (op == OP_STEP) || (op == OP_HOLD);
    we         = wr_allowed ? lane_req : '0;
    rd_req     = (op == OP_START_RD) ||
                 (((op == OP_STEP) || (op == OP_HOLD)) && !any_wr);
  end

endmodule

// File: rtl/bsram_burst_addr.sv
module bsram_burst_addr
  import bsram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_op_e       op,
  input  logic [AW-1:0] ext_addr,
  input  logic          ilv,
  output logic [AW-1:0] addr_use,
  output logic [AW-1:0] addr_q
);

  localparam int CB = 2;

  logic [AW-1:0] base_q, base_d;
  logic [CB-1:0] cnt_q, cnt_d;
  logic          base_en;

  // Next-state logic
  always_comb begin
    base_en = 1'b0;
    base_d  = base_q;
    cnt_d   = cnt_q;
    unique case (op)
      OP_START_RD, OP_START_WR: begin
        base_en = 1'b1;
        base_d  = ext_addr;
        cnt_d   = '0;
      end
      OP_STEP: cnt_d = cnt_q + 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_comb begin
    if (base_en)
      addr_use = ext_addr;
    else
      addr_use = {base_q[AW-1:CB], beat_low(base_q[CB-1:0], cnt_d, ilv)};
  end

  assign addr_q = {base_q[AW-1:CB], beat_low(base_q[CB-1:0], cnt_q, ilv)};

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (base_en) base_q <= base_d;
      cnt_q <= cnt_d;
    end
  end

  // R8
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOLD) |=> $stable(addr_q));

  // R6
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP && !ilv) |=>
      (ilv || (addr_q[CB-1:0] == $past(addr_q[CB-1:0]) + 2'd1 &&
               addr_q[AW-1:CB] == $past(addr_q[AW-1:CB]))));

endmodule

// File: rtl/bsram_lane_array.sv
module bsram_lane_array #(
  parameter int AW    = 6,
  parameter int LANES = 2,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic [LANES-1:0]    we,
  input  logic [AW-1:0]       waddr,
  input  logic [LANES*LW-1:0] wdata,
  input  logic [AW-1:0]       raddr,
  output logic [LANES*LW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[i]) mem[waddr] <= wdata[i*LW +: LW];
    end

    assign rdata[i*LW +: LW] = mem[raddr];
  end

endmodule

// File: rtl/bsram_out_stage.sv
module bsram_out_stage #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [DW-1:0] rdata,
  input  logic          out_en_n,
  output logic [DW-1:0] dout,
  output logic          drive
);

  logic          pend_q, pend_d;
  logic          vld_q, vld_d;
  logic [DW-1:0] data_q;

  always_comb begin
    pend_d = rd_req;
    vld_d  = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      vld_q  <= vld_d;
    end
  end

  // Data register has no reset; it loads only for a pending read.
  always_ff @(posedge clk) begin
    if (pend_q) data_q <= rdata;
  end

  assign drive = vld_q && !out_en_n;
  assign dout  = drive ? data_q : '0;

  // R11
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> !out_en_n);

endmodule

// File: rtl/bsram_cycle_ctl.sv
module bsram_cycle_ctl
  import bsram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 2,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs0_n,
  input  logic                cs1,
  input  logic                cs2_n,
  input  logic                start_cpu_n,
  input  logic                start_ctl_n,
  input  logic                next_n,
  input  logic [AW-1:0]       addr,
  input  logic                burst_ilv,
  input  logic                wr_all_n,
  input  logic                lane_wr_en_n,
  input  logic [LANES-1:0]    lane_sel_n,
  input  logic                out_en_n,
  input  logic [LANES*LW-1:0] dq_in,
  output logic [LANES*LW-1:0] dq_out,
  output logic                dq_drive
);

  localparam int DW = LANES * LW;

  cyc_op_e          op;
  logic [LANES-1:0] we;
  logic             rd_req;
  logic [AW-1:0]    addr_use;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    rdata;

  bsram_cmd_decode #(.LANES(LANES)) u_dec (
    .cs0_n        (cs0_n),
    .cs1          (cs1),
    .cs2_n        (cs2_n),
    .start_cpu_n  (start_cpu_n),
    .start_ctl_n  (start_ctl_n),
    .next_n       (next_n),
    .wr_all_n     (wr_all_n),
    .lane_wr_en_n (lane_wr_en_n),
    .lane_sel_n   (lane_sel_n),
    .op           (op),
    .we           (we),
    .rd_req       (rd_req)
  );

  bsram_burst_addr #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .ext_addr (addr),
    .ilv      (burst_ilv),
    .addr_use (addr_use),
    .addr_q   (addr_q)
  );

  bsram_lane_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_arr (
    .clk   (clk),
    .we    (we),
    .waddr (addr_use),
    .wdata (dq_in),
    .raddr (addr_q),
    .rdata (rdata)
  );

  bsram_out_stage #(.DW(DW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rdata    (rdata),
    .out_en_n (out_en_n),
    .dout     (dq_out),
    .drive    (dq_drive)
  );

  // R2
  desel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DESEL) |=> ##1 !dq_drive);

  // R3
  cpu_start_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_cpu_n && !cs0_n) |-> (we == '0));

  // R9
  global_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_all_n && op == OP_START_WR) |-> (&we));

endmodule

// File: tb/bsram_cycle_ctl_tb_top.sv
module bsram_cycle_ctl_tb_top;

  localparam int AW = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs0_n, cs1, cs2_n;
  logic        start_cpu_n, start_ctl_n, next_n;
  logic [AW-1:0] addr;
  logic        burst_ilv;
  logic        wr_all_n, lane_wr_en_n;
  logic [1:0]  lane_sel_n;
  logic        out_en_n;
  logic [15:0] dq_in, dq_out;
  logic        dq_drive;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [15:0] model [64];

  always #5 clk = ~clk;

  bsram_cycle_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .start_cpu_n(start_cpu_n), .start_ctl_n(start_ctl_n), .next_n(next_n),
    .addr(addr), .burst_ilv(burst_ilv), .wr_all_n(wr_all_n),
    .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
    .out_en_n(out_en_n), .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic no_write();
    wr_all_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = 2'b11;
  endtask

  task automatic select_all();
    cs0_n = 1'b0; cs1 = 1'b1; cs2_n = 1'b0;
  endtask

  // Deselect cycle: controller strobe low, cs0_n high.
  task automatic nop();
    cs0_n = 1'b1; cs1 = 1'b1; cs2_n = 1'b0;
    start_cpu_n = 1'b1; start_ctl_n = 1'b0; next_n = 1'b1;
    no_write();
    step();
  endtask

  task automatic ctl_write(input logic [AW-1:0] a, input logic [15:0] d);
    select_all();
    start_cpu_n = 1'b1; start_ctl_n = 1'b0; next_n = 1'b1;
    wr_all_n = 1'b0; lane_wr_en_n = 1'b1; lane_sel_n = 2'b11;
    addr = a; dq_in = d;
    step();
    model[a] = d;
  endtask

  task automatic cpu_read(input logic [AW-1:0] a);
    select_all();
    start_cpu_n = 1'b0; start_ctl_n = 1'b1; next_n = 1'b1;
    no_write();
    addr = a;
    step();
  endtask

  task automatic burst_cont(input logic adv);
    select_all();
    start_cpu_n = 1'b1; start_ctl_n = 1'b1; next_n = ~adv;
    no_write();
    step();
  endtask

  // Read one word and check it, including the pipeline stage (R12).
  task automatic read_check(input string tag, input logic [AW-1:0] a);
    cpu_read(a);
    nop();
    check({tag, " data"}, dq_out, model[a]);
    check({tag, " drive"}, dq_drive, 1'b1);
    nop();
  endtask

  task automatic t_reset();
    // R1
    check("R1 drive in reset", dq_drive, 1'b0);
    rst_n = 1'b1;
    nop();
    check("R1 drive after reset", dq_drive, 1'b0);
  endtask

  task automatic t_latency();
    ctl_write(6'd5, 16'hA5A5);  // R5 controller write start, R9 global
    cpu_read(6'd5);
    // R12: nothing yet after the capture edge
    check("R12 no data after capture edge", dq_drive, 1'b0);
    nop();
    check("R12 data after next edge", dq_out, 16'hA5A5);
    check("R12 drive after next edge", dq_drive, 1'b1);
    nop();
  endtask

  task automatic t_cpu_ignores_write();
    // R3: processor start with every write control asserted
    select_all();
    start_cpu_n = 1'b0; start_ctl_n = 1'b1; next_n = 1'b1;
    wr_all_n = 1'b0; lane_wr_en_n = 1'b0; lane_sel_n = 2'b00;
    addr = 6'd5; dq_in = 16'hFFFF;
    step();
    nop();
    check("R3 reads instead of writing", dq_out, 16'hA5A5);
    nop();
    read_check("R3 array unchanged", 6'd5);
  endtask

  task automatic t_lanes();
    ctl_write(6'd9, 16'h0000);
    select_all();
    start_cpu_n = 1'b1; start_ctl_n = 1'b0; next_n = 1'b1;
    wr_all_n = 1'b1; lane_wr_en_n = 1'b0; lane_sel_n = 2'b10;
    addr = 6'd9; dq_in = 16'hABCD;
    step();
    model[9] = 16'h00CD;
    nop();
    read_check("R10 lane0 only", 6'd9);
    select_all();
    start_cpu_n = 1'b1; start_ctl_n = 1'b0; next_n = 1'b1;
    wr_all_n = 1'b1; lane_wr_en_n = 1'b0; lane_sel_n = 2'b01;
    addr = 6'd9; dq_in = 16'h12EF;
    step();
    model[9] = 16'h12CD;
    nop();
    read_check("R10 lane1 only", 6'd9);
    // R10: both lane selects high -> read, no write
    select_all();
    start_cpu_n = 1'b1; start_ctl_n = 1'b0; next_n = 1'b1;
    wr_all_n = 1'b1; lane_wr_en_n = 1'b0; lane_sel_n = 2'b11;
    addr = 6'd9; dq_in = 16'hFFFF;
    step();
    nop();
    check("R10 no lanes becomes read", dq_out, 16'h12CD);
    check("R10 no lanes drives bus", dq_drive, 1'b1);
    nop();
  endtask

  task automatic t_global();
    // R9: global write with lane controls all inactive
    select_all();
    start_cpu_n = 1'b1; start_ctl_n = 1'b0; next_n = 1'b1;
    wr_all_n = 1'b0; lane_wr_en_n = 1'b1; lane_sel_n = 2'b11;
    addr = 6'd9; dq_in = 16'h7E81;
    step();
    model[9] = 16'h7E81;
    nop();
    read_check("R9 global write overrides", 6'd9);
  endtask

  task automatic t_deselect();
    for (int k = 0; k < 3; k++) begin
      select_all();
      if (k == 0) cs0_n = 1'b1;
      if (k == 1) cs1   = 1'b0;
      if (k == 2) cs2_n = 1'b1;
      start_cpu_n = 1'b1; start_ctl_n = 1'b0; next_n = 1'b1;
      wr_all_n = 1'b0; addr = 6'd5; dq_in = 16'hDEAD;
      step();
      no_write();
      start_ctl_n = 1'b1;
      step();
      check($sformatf("R2 bus released case %0d", k), dq_drive, 1'b0);
    end
    // R2: processor strobe with cs1 low is also a deselect
    select_all(); cs1 = 1'b0;
    start_cpu_n = 1'b0; start_ctl_n = 1'b1; next_n = 1'b1; addr = 6'd5;
    step();
    start_cpu_n = 1'b1;
    step();
    check("R2 cpu strobe deselect", dq_drive, 1'b0);
    nop();
    read_check("R2 array unchanged", 6'd5);
  endtask

  task automatic preload();
    for (int i = 16; i < 24; i++) ctl_write(i[AW-1:0], 16'h0A00 + 16'(i));
  endtask

  task automatic t_cpu_ignored();
    cpu_read(6'd16);
    // R4: cs0_n high, processor strobe low, advance low -> step to 17
    cs0_n = 1'b1; cs1 = 1'b1; cs2_n = 1'b0;
    start_cpu_n = 1'b0; start_ctl_n = 1'b1; next_n = 1'b0;
    no_write(); addr = 6'd40;
    step();
    check("R4 first beat", dq_out, model[16]);
    nop();
    check("R4 steps, no new start", dq_out, model[17]);
    nop();
  endtask

  task automatic burst_read(input string tag, input logic ilv, input logic [AW-1:0] a);
    logic [AW-1:0] exp_a;
    burst_ilv = ilv;
    cpu_read(a);
    for (int k = 1; k < 5; k++) begin
      if (k < 4) burst_cont(1'b1); else nop();
      exp_a = {a[AW-1:2], ilv ? (a[1:0] ^ 2'(k-1)) : (a[1:0] + 2'(k-1))};
      check($sformatf("%s beat %0d", tag, k-1), dq_out, model[exp_a]);
    end
    nop();
    burst_ilv = 1'b0;
  endtask

  task automatic t_hold();
    // R8: start 17, step 18, hold, hold, step 19
    cpu_read(6'd17);
    burst_cont(1'b1);
    check("R8 beat start", dq_out, model[17]);
    burst_cont(1'b0);
    check("R8 stepped", dq_out, model[18]);
    burst_cont(1'b0);
    check("R8 hold 1", dq_out, model[18]);
    burst_cont(1'b1);
    check("R8 hold 2", dq_out, model[18]);
    nop();
    check("R8 step after hold", dq_out, model[19]);
    nop();
  endtask

  task automatic t_write_burst();
    // R5 write start then R6 write steps, data taken at each edge (R12)
    select_all();
    start_cpu_n = 1'b1; start_ctl_n = 1'b0; next_n = 1'b1;
    wr_all_n = 1'b0; addr = 6'd22; dq_in = 16'h3000;
    step();
    start_ctl_n = 1'b1; next_n = 1'b0; dq_in = 16'h3001;
    step();
    dq_in = 16'h3002;
    step();
    model[22] = 16'h3000; model[23] = 16'h3001; model[20] = 16'h3002;
    nop();
    read_check("R5 write burst beat0", 6'd22);
    read_check("R6 write burst beat1", 6'd23);
    read_check("R6 write burst wraps", 6'd20);
  endtask

  task automatic t_oe();
    cpu_read(6'd21);
    nop();
    check("R11 drive with oe low", dq_drive, 1'b1);
    out_en_n = 1'b1;
    #1;
    check("R11 oe high releases at once", dq_drive, 1'b0);
    out_en_n = 1'b0;
    #1;
    check("R11 oe low drives again", dq_drive, 1'b1);
    check("R11 data held", dq_out, model[21]);
    nop();
  endtask

  initial begin
    rst_n = 1'b0;
    cs0_n = 1'b1; cs1 = 1'b1; cs2_n = 1'b0;
    start_cpu_n = 1'b1; start_ctl_n = 1'b0; next_n = 1'b1;
    addr = '0; burst_ilv = 1'b0; out_en_n = 1'b0; dq_in = '0;
    no_write();
    for (int i = 0; i < 64; i++) model[i] = 16'h0;
    repeat (3) step();
    t_reset();
    t_latency();
    t_cpu_ignores_write();
    t_lanes();
    t_global();
    t_deselect();
    preload();
    t_cpu_ignored();
    burst_read("R6 linear from 17", 1'b0, 6'd17);
    burst_read("R6 linear from 19", 1'b0, 6'd19);
    burst_read("R7 interleaved from 17", 1'b1, 6'd17);
    burst_read("R7 interleaved from 22", 1'b1, 6'd22);
    t_hold();
    t_write_burst();
    t_oe();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule